// File: doc/BRIEF.md
# Postfix Stack Calculator Core

This block is a small stack machine that evaluates a postfix program of 9-bit words. The program sits in a 16-word memory that is filled from a parameter whenever reset is applied. One memory port feeds a program counter and instruction register. The other port is the operand stack, addressed by a stack pointer. The two topmost operands are kept in registers: A holds the deeper one and B the top one. Anything below them spills to memory.

Fetching the next word overlaps with executing the current one, so one word is consumed per clock. A controller tracks how many operands are live and keeps them in registers and on the stack. It rejects malformed programs with a sticky error flag. A well-formed program ends in a sticky halt, with the final value on the result output. The program image is chosen per instance through a parameter, which is how the block is used in a larger design.

Top module: `stack_calc_core`

## Requirements
- R1: A word with bit 8 clear is an operand. Its bits 7..0 are sign-extended to 9 bits and loaded into B, and result_o always shows B.
- R2: An operand arriving while A and B both hold values writes A to the stack at the stack pointer, increments the pointer, and moves B into A.
- R3: Word 0x100 replaces the top two operands with deeper minus top, and word 0x101 replaces them with their sum. The result goes into B.
- R4: Arithmetic wraps modulo 2^9 in two's complement.
- R5: After an operator, if spilled entries exist, the pointer is decremented and A is refilled from that address, so arbitrarily deep expressions reduce correctly.
- R6: Word 0x1FF with exactly one live operand sets halt_o. From then on halt_o and result_o hold until reset.
- R7: An add or subtract with fewer than two live operands sets error_o, leaves result_o unchanged, and holds until reset.
- R8: Word 0x1FF with zero operands, or with two or more operands, sets error_o instead of halt_o.
- R9: A word with bit 8 set that is not 0x100, 0x101 or 0x1FF sets error_o.
- R10: After reset is released, program word k (from 0) is executed on clock edge k+2, one word per cycle. Its effect is visible right after that edge.
- R11: While reset is low, result_o is 0 and both flags are low. Memory is reloaded from PROGRAM, with word i at bits 9i+8..9i. A run after a mid-program reset repeats the first run.
- R12: halt_o and error_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; reloads the program |
| result_o | output | 9 | Top-of-stack register B, two's complement |
| halt_o | output | 1 | Program finished with one operand |
| error_o | output | 1 | Malformed program detected |

## Verification
The bench runs eight program images side by side and compares them against a list-based model on every clock. The images cover:
- the standard mixed expression;
- a chain of additions that overflows nine bits;
- a subtraction with a negative operand;
- a seven-deep expression that spills five entries and reduces them all again;
- an operator with one operand;
- end markers arriving with two operands or with none;
- an undefined opcode.

A wrong operand order shows up as a sign flip in the subtraction result. A missing pop or an off-by-one address shows up as a wrong value in the deep case. Weak depth tracking lets the malformed programs halt instead of raising the error. A mid-run reset, followed by a second run, catches state that survives reset.

// File: rtl/stack_calc_pkg.sv
package stack_calc_pkg;
  localparam int WORD_W = 9;
  localparam logic [WORD_W-1:0] OP_SUB = 9'h100;
  localparam logic [WORD_W-1:0] OP_ADD = 9'h101;
  localparam logic [WORD_W-1:0] OP_END = 9'h1FF;

  // live operand count: empty, B only, A+B, A+B+1 spilled, deeper
  typedef enum logic [2:0] {
    ST_EMPTY, ST_ONE, ST_TWO, ST_THREE, ST_DEEP, ST_HALT, ST_ERR
  } depth_e;

  typedef struct packed {
    logic load;   // B <= operand
    logic shift;  // A <= B
    logic push;   // mem[sp] <= A, sp++
    logic alu;    // B <= A op B
    logic sub;
    logic pop;    // sp--, A <= mem[sp]
  } ctl_t;
endpackage

// File: rtl/stack_calc_mem.sv
module stack_calc_mem
  import stack_calc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 1 << ADDR_W,
  parameter logic [DEPTH*WORD_W-1:0] PROGRAM = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] stk_addr_i,
  input  logic              stk_we_i,
  input  logic [WORD_W-1:0] stk_wdata_i,
  output logic [WORD_W-1:0] stk_rdata_o,
  input  logic [ADDR_W-1:0] prg_addr_i,
  output logic [WORD_W-1:0] prg_rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= PROGRAM[i*WORD_W +: WORD_W];
    end else if (stk_we_i) begin
      mem_q[stk_addr_i] <= stk_wdata_i;
    end
  end

  assign stk_rdata_o = mem_q[stk_addr_i];
  assign prg_rdata_o = mem_q[prg_addr_i];
endmodule

// File: rtl/stack_calc_fetch.sv
module stack_calc_fetch
  import stack_calc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  output logic [ADDR_W-1:0] prg_addr_o,
  input  logic [WORD_W-1:0] prg_rdata_i,
  output logic [WORD_W-1:0] ir_o,
  output logic              ir_valid_o
);
  logic [ADDR_W-1:0] pc_q;
  logic [WORD_W-1:0] ir_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      ir_q    <= '0;
      valid_q <= 1'b0;
    end else if (run_i) begin
      ir_q    <= prg_rdata_i;
      pc_q    <= pc_q + 1'b1;
      valid_q <= 1'b1;
    end
  end

  assign prg_addr_o = pc_q;
  assign ir_o       = ir_q;
  assign ir_valid_o = valid_q;

  a_r10_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(pc_q));
  a_r10_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> pc_q == ADDR_W'($past(pc_q) + 1'b1));
endmodule

// File: rtl/stack_calc_ctrl.sv
module stack_calc_ctrl
  import stack_calc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] ir_i,
  input  logic              ir_valid_i,
  input  logic              sp_two_i,
  output ctl_t              ctl_o,
  output logic              run_o,
  output logic              halt_o,
  output logic              error_o
);
  depth_e state_q, state_d;
  logic   is_arith;

  assign is_arith = (ir_i == OP_SUB) || (ir_i == OP_ADD);

  always_comb begin
    ctl_o   = '0;
    state_d = state_q;
    if (ir_valid_i && run_o) begin
      if (!ir_i[WORD_W-1]) begin
        ctl_o.load = 1'b1;
        unique case (state_q)
          ST_EMPTY: state_d = ST_ONE;
          ST_ONE: begin
            ctl_o.shift = 1'b1;
            state_d     = ST_TWO;
          end
          ST_TWO: begin
            ctl_o.shift = 1'b1;
            ctl_o.push  = 1'b1;
            state_d     = ST_THREE;
          end
          default: begin
            ctl_o.shift = 1'b1;
            ctl_o.push  = 1'b1;
            state_d     = ST_DEEP;
          end
        endcase
      end else if (is_arith) begin
        ctl_o.sub = (ir_i == OP_SUB);
        unique case (state_q)
          ST_TWO: begin
            ctl_o.alu = 1'b1;
            state_d   = ST_ONE;
          end
          ST_THREE: begin
            ctl_o.alu = 1'b1;
            ctl_o.pop = 1'b1;
            state_d   = ST_TWO;
          end
          ST_DEEP: begin
            ctl_o.alu = 1'b1;
            ctl_o.pop = 1'b1;
            state_d   = sp_two_i ? ST_THREE : ST_DEEP;
          end
          default: state_d = ST_ERR;
        endcase
      end else if (ir_i == OP_END) begin
        state_d = (state_q == ST_ONE) ? ST_HALT : ST_ERR;
      end else begin
        state_d = ST_ERR;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_EMPTY;
    else         state_q <= state_d;
  end

  assign run_o   = (state_q != ST_HALT) && (state_q != ST_ERR);
  assign halt_o  = (state_q == ST_HALT);
  assign error_o = (state_q == ST_ERR);

  a_r7_error_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o);
  a_r6_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
  a_r12_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(halt_o && error_o));
  a_r7_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_valid_i && is_arith && (state_q == ST_EMPTY || state_q == ST_ONE)) |=> error_o);
endmodule

// File: rtl/stack_calc_dp.sv
module stack_calc_dp
  import stack_calc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic [7:0]        operand_i,
  output logic [ADDR_W-1:0] stk_addr_o,
  output logic              stk_we_o,
  output logic [WORD_W-1:0] stk_wdata_o,
  input  logic [WORD_W-1:0] stk_rdata_i,
  output logic              sp_two_o,
  output logic [WORD_W-1:0] b_o
);
  logic [WORD_W-1:0] a_q, b_q, alu_res;
  logic [ADDR_W-1:0] sp_q;

  assign alu_res     = ctl_i.sub ? (a_q - b_q) : (a_q + b_q);
  assign stk_addr_o  = ctl_i.pop ? (sp_q - 1'b1) : sp_q;
  assign stk_we_o    = ctl_i.push;
  assign stk_wdata_o = a_q;
  assign sp_two_o    = (sp_q == ADDR_W'(2));
  assign b_o         = b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= '0;
      b_q  <= '0;
      sp_q <= '0;
    end else begin
      if (ctl_i.push)     sp_q <= sp_q + 1'b1;
      else if (ctl_i.pop) sp_q <= sp_q - 1'b1;
      if (ctl_i.pop)        a_q <= stk_rdata_i;
      else if (ctl_i.shift) a_q <= b_q;
      if (ctl_i.alu)       b_q <= alu_res;
      else if (ctl_i.load) b_q <= {operand_i[7], operand_i};
    end
  end

  a_r5_sp_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_q == $past(sp_q)) || (sp_q == ADDR_W'($past(sp_q) + 1'b1))
      || (sp_q == ADDR_W'($past(sp_q) - 1'b1)));
  a_r5_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.pop |-> sp_q != '0);
  a_r2_push_holds_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.push |=> a_q == $past(b_q));
endmodule

// File: rtl/stack_calc_core.sv
module stack_calc_core
  import stack_calc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 1 << ADDR_W,
  parameter logic [DEPTH*WORD_W-1:0] PROGRAM = {
    {8{9'h000}}, 9'h1FF, 9'h101, 9'h101, 9'h100, 9'h006, 9'h008, 9'h005, 9'h003}
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [8:0]   result_o,
  output logic         halt_o,
  output logic         error_o
);
  logic [ADDR_W-1:0] stk_addr, prg_addr;
  logic              stk_we, ir_valid, run, sp_two;
  logic [WORD_W-1:0] stk_wdata, stk_rdata, prg_rdata, ir;
  ctl_t              ctl;

  stack_calc_mem #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .PROGRAM(PROGRAM)) u_mem (
    .clk_i, .rst_ni,
    .stk_addr_i(stk_addr), .stk_we_i(stk_we), .stk_wdata_i(stk_wdata),
    .stk_rdata_o(stk_rdata), .prg_addr_i(prg_addr), .prg_rdata_o(prg_rdata)
  );

  stack_calc_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk_i, .rst_ni, .run_i(run), .prg_addr_o(prg_addr),
    .prg_rdata_i(prg_rdata), .ir_o(ir), .ir_valid_o(ir_valid)
  );

  stack_calc_ctrl u_ctrl (
    .clk_i, .rst_ni, .ir_i(ir), .ir_valid_i(ir_valid), .sp_two_i(sp_two),
    .ctl_o(ctl), .run_o(run), .halt_o, .error_o
  );

  stack_calc_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk_i, .rst_ni, .ctl_i(ctl), .operand_i(ir[7:0]),
    .stk_addr_o(stk_addr), .stk_we_o(stk_we), .stk_wdata_o(stk_wdata),
    .stk_rdata_i(stk_rdata), .sp_two_o(sp_two), .b_o(result_o)
  );

  a_r6_result_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> $stable(result_o));
  a_r7_result_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> $stable(result_o));
endmodule

// File: tb/stack_calc_core_tb.sv
module stack_calc_core_tb;
  localparam int NP = 8;
  localparam int NW = 16;
  localparam int NCYC = 64;

  localparam logic [8:0] PROGS [NP][NW] = '{
    '{9'h003, 9'h005, 9'h008, 9'h006, 9'h100, 9'h101, 9'h101, 9'h1FF,
      9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h07F, 9'h07F, 9'h101, 9'h07F, 9'h101, 9'h07F, 9'h101, 9'h1FF,
      9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h005, 9'h0F9, 9'h100, 9'h1FF, 9'h000, 9'h000, 9'h000, 9'h000,
      9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h004, 9'h101, 9'h006, 9'h1FF, 9'h000, 9'h000, 9'h000, 9'h000,
      9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h001, 9'h002, 9'h1FF, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000,
      9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h001, 9'h002, 9'h1AA, 9'h1FF, 9'h000, 9'h000, 9'h000, 9'h000,
      9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h001, 9'h002, 9'h003, 9'h004, 9'h005, 9'h006, 9'h007, 9'h100,
      9'h100, 9'h100, 9'h100, 9'h100, 9'h100, 9'h1FF, 9'h000, 9'h000},
    '{9'h1FF, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000,
      9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000}
  };

  function automatic logic [NW*9-1:0] pack_prog(int p);
    logic [NW*9-1:0] v = '0;
    for (int i = 0; i < NW; i++) v[i*9 +: 9] = PROGS[p][i];
    return v;
  endfunction

  function automatic string prog_tag(int p);
    case (p)
      0: return "R1/R2/R3/R5/R6";
      1: return "R4";
      2: return "R3";
      3: return "R7";
      4: return "R8";
      5: return "R9";
      6: return "R5";
      default: return "R8";
    endcase
  endfunction

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [8:0] res_w [NP];
  logic       halt_w [NP];
  logic       err_w [NP];

  always #10 clk_i = ~clk_i;

  for (genvar g = 0; g < NP; g++) begin : g_dut
    logic [8:0] r;
    logic h, e;
    stack_calc_core #(.PROGRAM(pack_prog(g))) u_dut (
      .clk_i(clk_i), .rst_ni(rst_ni), .result_o(r), .halt_o(h), .error_o(e));
    assign res_w[g]  = r;
    assign halt_w[g] = h;
    assign err_w[g]  = e;
  end

  int checks = 0;
  int errors = 0;

  // behavioural reference
  logic [8:0] mstk [NP][NW];
  int         msz [NP];
  int         mpc [NP];
  bit         mval [NP];
  logic [8:0] mir [NP];
  bit         mhalt [NP];
  bit         merr [NP];
  logic [8:0] mres [NP];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      msz[p] = 0; mpc[p] = 0; mval[p] = 0; mir[p] = '0;
      mhalt[p] = 0; merr[p] = 0; mres[p] = '0;
    end
  endtask

  task automatic model_exec(int p, logic [8:0] w);
    logic [8:0] a, b, r;
    if (!w[8]) begin
      mstk[p][msz[p]] = {w[7], w[7:0]};
      msz[p]++;
      mres[p] = {w[7], w[7:0]};
    end else if (w == 9'h100 || w == 9'h101) begin
      if (msz[p] < 2) merr[p] = 1;
      else begin
        b = mstk[p][msz[p]-1];
        a = mstk[p][msz[p]-2];
        r = (w == 9'h100) ? a - b : a + b;
        msz[p]--;
        mstk[p][msz[p]-1] = r;
        mres[p] = r;
      end
    end else if (w == 9'h1FF) begin
      if (msz[p] == 1) mhalt[p] = 1;
      else merr[p] = 1;
    end else merr[p] = 1;
  endtask

  task automatic model_step();
    if (!rst_ni) model_reset();
    else for (int p = 0; p < NP; p++) begin
      if (!mhalt[p] && !merr[p]) begin
        if (mval[p]) model_exec(p, mir[p]);
        mir[p]  = PROGS[p][mpc[p]];
        mpc[p]  = (mpc[p] + 1) % NW;
        mval[p] = 1;
      end
    end
  endtask

  task automatic compare_all();
    for (int p = 0; p < NP; p++) begin
      check(res_w[p] == mres[p], {"R10/", prog_tag(p)}, $sformatf("prog%0d result", p),
            res_w[p], mres[p]);
      check(halt_w[p] == mhalt[p], prog_tag(p), $sformatf("prog%0d halt", p),
            halt_w[p], mhalt[p]);
      check(err_w[p] == merr[p], prog_tag(p), $sformatf("prog%0d error", p),
            err_w[p], merr[p]);
      check(!(halt_w[p] && err_w[p]), "R12", $sformatf("prog%0d both flags", p),
            {halt_w[p], err_w[p]}, 0);
    end
  endtask

  task automatic final_checks(string tag);
    check(halt_w[0] && res_w[0] == 9'd10, {tag, "/R6"}, "3 5 8 6 - + + halts with 10",
          res_w[0], 10);
    check(halt_w[1] && res_w[1] == 9'h1FC, {tag, "/R4"}, "wrapped sum", res_w[1], 9'h1FC);
    check(halt_w[2] && res_w[2] == 9'd12, {tag, "/R3"}, "5 minus -7", res_w[2], 12);
    check(err_w[3] && res_w[3] == 9'd4, {tag, "/R7"}, "underflow keeps result",
          res_w[3], 4);
    check(err_w[4] && !halt_w[4], {tag, "/R8"}, "end with two operands", err_w[4], 1);
    check(err_w[5], {tag, "/R9"}, "undefined opcode", err_w[5], 1);
    check(halt_w[6] && res_w[6] == 9'd4, {tag, "/R5"}, "deep reduction", res_w[6], 4);
    check(err_w[7] && !halt_w[7], {tag, "/R8"}, "end with no operand", err_w[7], 1);
  endtask

  initial begin
    model_reset();
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(posedge clk_i);
      #1;
      model_step();
      @(negedge clk_i);
      compare_all();
      if (cyc == 1) begin
        check(res_w[0] == 9'd0 && !halt_w[0] && !err_w[0], "R11", "reset state",
              res_w[0], 0);
      end
      if (cyc == 3) check(res_w[0] == 9'd0, "R10", "no result after first edge",
                          res_w[0], 0);
      if (cyc == 4) check(res_w[0] == 9'd3, "R10", "word 0 on second edge",
                          res_w[0], 3);
      if (cyc == 5) check(res_w[0] == 9'd5, "R10/R1", "word 1 on third edge",
                          res_w[0], 5);
      if (cyc == 30) final_checks("R1");
      if (cyc == 35) check(res_w[0] == 9'd0 && !halt_w[0], "R11", "mid-run reset clears",
                           res_w[0], 0);
      if (cyc == NCYC - 1) final_checks("R11");
      if (cyc == 2)  rst_ni = 1'b1;
      if (cyc == 34) rst_ni = 1'b0;
      if (cyc == 36) rst_ni = 1'b1;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule